// File: doc/BRIEF.md
# Buffered Serial Transmitter with Empty-Flag Interrupt

This block sends bytes on a single serial line. A one-byte holding register sits in front of a frame shift register, so the CPU can write the next byte while the current one is still going out. A status flag tells the CPU when the holding register can take another byte. An interrupt request is raised for as long as that flag is set and the interrupt enable is on. The flag is 1 out of reset. It cannot be written directly: only a byte write clears it, and only the move of that byte into the shift register sets it again.

The bit rate comes from an external one-cycle tick. Each serial bit is held until the next tick. There are three framings. Plain asynchronous mode has a start bit, eight data bits and a stop bit. The addressed asynchronous mode adds one extra address/data bit before the stop bit. Synchronous mode sends the eight data bits only, and consecutive bytes follow each other with no gap. The mode and the address bit are captured when a byte enters the shift register.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset, `hold_empty` is 1, `tx_busy` is 0, `txd` is 1 and `tx_irq` is 0 while `irq_en` is 0.
- R2: `tx_irq` is 1 in exactly those cycles where `irq_en` is 1 and `hold_empty` is 1. Setting `irq_en` right after reset raises it in that same cycle.
- R3: A data write (`wr_en` high for one cycle) makes `hold_empty` 0 after that clock edge. A write while `hold_empty` is 0 replaces the pending byte and leaves the flag at 0. Only the last byte written is sent.
- R4: `hold_empty` returns to 1 at the clock edge on which the pending byte moves into the shift register. When the shifter is idle, this is the edge right after the write edge, and the first frame bit appears on `txd` at that same edge.
- R5: With `mode` = 2'b00, a frame is 10 bits: a start bit of 0, then data bits 0 to 7 (least significant first), then a stop bit of 1.
- R6: With `mode` = 2'b01, a frame is 11 bits: start 0, data bits 0 to 7, then the value of `addr_bit`, then stop 1.
- R7: With `mode` = 2'b10 or 2'b11, only data bits 0 to 7 are sent. A byte that is pending when the previous byte's last bit ends follows at once, and `tx_busy` stays high across the join.
- R8: Each frame bit stays on `txd` until a clock edge with `bit_tick` high. Exactly one tick ends each bit. The pending byte is loaded on the tick edge that ends the previous frame's last bit.
- R9: While no frame is in progress, `txd` is 1 and `tx_busy` is 0.
- R10: `mode` and `addr_bit` are sampled when a byte is loaded into the shift register. Changing them later has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| mode | input | 2 | Framing: 00 async, 01 async with address bit, 1x synchronous |
| addr_bit | input | 1 | Address/data bit value for mode 01 |
| irq_en | input | 1 | Transmit interrupt enable |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_busy | output | 1 | A frame is being shifted out |
| tx_irq | output | 1 | Level interrupt request |
| txd | output | 1 | Serial output |

## Verification
Random bursts of random bytes are sent in each of the three modes. The bench captures the bit that `txd` holds at every tick and compares it with the frame bits it builds on its own. This check tells the framings apart by length and content, shows whether bits come out least significant first, and, in the addressed mode, shows whether the extra bit takes its value from the input. Synchronous bursts also count falling edges of `tx_busy`, so a one-cycle gap between chained bytes would be caught. Directed cases cover the reset state, the interrupt right after enable, the flag around a write on an idle shifter, an overwrite of a pending byte, and a change of mode and address bit just after a load.

// File: rtl/tx_pkg.sv
// Shared types for the buffered serial transmitter.
// Assumes a two-bit mode field in which the upper bit selects synchronous framing.
package tx_pkg;
    typedef enum logic [1:0] {
        FRM_ASYNC      = 2'b00,
        FRM_ASYNC_ADDR = 2'b01,
        FRM_SYNC       = 2'b10,
        FRM_SYNC_ALT   = 2'b11
    } frame_mode_e;
endpackage

// File: rtl/tx_hold_reg.sv
// Holding register: stores one byte written by the CPU and reports whether it is empty.
// Assumes the shifter pulses take_i for one cycle when it moves the byte out.
// A write in the same cycle as a take wins, so the new byte stays pending.
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);
    // Purpose: capture written bytes and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            data_o <= '0;
        end else if (wr_en_i) begin
            full_o <= 1'b1;
            data_o <= wr_data_i;
        end else if (take_i) begin
            full_o <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_frame_shifter.sv
// Frame shifter: builds a frame from the pending byte and shifts it out one bit per tick.
// Assumes bit_tick is a one-cycle strobe. Loads on an idle cycle, or on the tick that
// ends the last bit of the current frame, so chained frames have no gap.
module tx_frame_shifter
    import tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              pend_i,
    input  logic [DATA_W-1:0] pend_data_i,
    input  logic [1:0]        mode_i,
    input  logic              addr_i,
    output logic              take_o,
    output logic              busy_o,
    output logic              txd_o
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               active;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bits_left;
    logic [FRAME_W-1:0] new_frame;
    logic [CNT_W-1:0]   new_len;
    logic               frame_end;
    frame_mode_e        fmode;

    assign fmode = frame_mode_e'(mode_i);

    // Purpose: assemble the frame bits and the frame length for the selected mode.
    always_comb begin
        new_frame = '1;
        new_len   = CNT_W'(DATA_W + 2);
        unique case (fmode)
            FRM_ASYNC: begin
                new_frame[0]        = 1'b0;
                new_frame[DATA_W:1] = pend_data_i;
            end
            FRM_ASYNC_ADDR: begin
                new_frame[0]          = 1'b0;
                new_frame[DATA_W:1]   = pend_data_i;
                new_frame[DATA_W+1]   = addr_i;
                new_len               = CNT_W'(DATA_W + 3);
            end
            default: begin
                new_frame[DATA_W-1:0] = pend_data_i;
                new_len               = CNT_W'(DATA_W);
            end
        endcase
    end

    // Purpose: decide when the last bit ends and when the pending byte is taken.
    always_comb begin
        frame_end = active && bit_tick && (bits_left == CNT_W'(1));
        take_o    = pend_i && (!active || frame_end);
    end

    // Purpose: load, shift and retire frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
        end else if (take_o) begin
            active    <= 1'b1;
            shreg     <= new_frame;
            bits_left <= new_len;
        end else if (frame_end) begin
            active    <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
        end else if (active && bit_tick) begin
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - CNT_W'(1);
        end
    end

    assign busy_o = active;
    assign txd_o  = active ? shreg[0] : 1'b1;
endmodule

// File: rtl/tx_irq_gate.sv
// Interrupt gate: drives a level request while the enable and the empty flag are both set.
// Assumes the downstream controller handles the level; nothing is latched here.
module tx_irq_gate (
    input  logic irq_en_i,
    input  logic empty_i,
    output logic irq_o
);
    // Purpose: combine enable and status into a level request.
    always_comb irq_o = irq_en_i & empty_i;
endmodule

// File: rtl/ser_tx_dbuf.sv
// Top of the buffered serial transmitter: holding register, frame shifter and interrupt gate.
// Assumes a synchronous active-low reset and an external bit-rate tick.
module ser_tx_dbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        mode,
    input  logic              addr_bit,
    input  logic              irq_en,
    output logic              hold_empty,
    output logic              tx_busy,
    output logic              tx_irq,
    output logic              txd
);
    logic              pend_full;
    logic [DATA_W-1:0] pend_data;
    logic              take;

    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .take_i    (take),
        .full_o    (pend_full),
        .data_o    (pend_data)
    );

    tx_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .pend_i      (pend_full),
        .pend_data_i (pend_data),
        .mode_i      (mode),
        .addr_i      (addr_bit),
        .take_o      (take),
        .busy_o      (tx_busy),
        .txd_o       (txd)
    );

    assign hold_empty = ~pend_full;

    tx_irq_gate u_irq (
        .irq_en_i (irq_en),
        .empty_i  (hold_empty),
        .irq_o    (tx_irq)
    );
endmodule

// File: rtl/ser_tx_dbuf_chk.sv
// Checker for the buffered serial transmitter, attached to every instance by bind.
// Assumes only the top-level ports are visible.
module ser_tx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic wr_en,
    input logic irq_en,
    input logic hold_empty,
    input logic tx_busy,
    input logic tx_irq,
    input logic txd
);
    // R3: a write leaves the holding register occupied
    a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

    // R3: the flag only falls on the edge of a write
    a_r3_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_empty) |-> $past(wr_en));

    // R4: the flag only rises when a byte enters the shifter
    a_r4_rise_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> tx_busy);

    // R2: no request without the enable
    a_r2_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !tx_irq);

    // R9: idle line is high
    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R8: the line only moves on a tick edge or when a frame starts
    a_r8_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(txd) && $past(rst_n)) |-> ($past(bit_tick) || $rose(tx_busy)));
endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .wr_en      (wr_en),
    .irq_en     (irq_en),
    .hold_empty (hold_empty),
    .tx_busy    (tx_busy),
    .tx_irq     (tx_irq),
    .txd        (txd)
);

// File: tb/sim_ser_tx_dbuf.sv
// Bench for ser_tx_dbuf: random bursts per mode plus directed corner cases.
module sim_ser_tx_dbuf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] mode = 2'b00;
    logic       addr_bit = 1'b0;
    logic       irq_en = 1'b0;
    logic       hold_empty, tx_busy, tx_irq, txd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int busy_falls = 0;
    bit prev_busy  = 1'b0;
    bit exp_q[$];
    bit got_q[$];

    always #4 clk = ~clk;

    ser_tx_dbuf u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .mode(mode), .addr_bit(addr_bit), .irq_en(irq_en),
        .hold_empty(hold_empty), .tx_busy(tx_busy), .tx_irq(tx_irq), .txd(txd)
    );

    // tick generator: one cycle in four
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            bit_tick = (cnt == 3);
            cnt = (cnt + 1) % 4;
        end
    end

    // monitor: record the bit held at each tick, count busy falls
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && bit_tick && tx_busy) got_q.push_back(txd);
            if (rst_n && prev_busy && !tx_busy) busy_falls++;
            prev_busy = tx_busy;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void push_frame(input logic [7:0] d, input logic [1:0] m, input bit a);
        if (!m[1]) exp_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
        if (m == 2'b01) exp_q.push_back(a);
        if (!m[1]) exp_q.push_back(1'b1);
    endfunction

    task automatic write_byte(input logic [7:0] d, input bit a);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; addr_bit = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        int guard = 0;
        @(negedge clk); #1;
        while (!hold_empty && guard < 2000) begin
            @(negedge clk); #1; guard++;
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk); #1;
        while ((tx_busy || !hold_empty) && guard < 5000) begin
            @(negedge clk); #1; guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic compare_stream(input string req);
        int bad = 0;
        if (got_q.size() != exp_q.size()) bad = 1;
        else for (int i = 0; i < exp_q.size(); i++) if (got_q[i] != exp_q[i]) bad++;
        check(bad == 0, req, got_q.size(), exp_q.size());
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic random_burst(input logic [1:0] m, input string req);
        int n = 3 + ($urandom % 4);
        int f0;
        wait_idle();
        mode = m;
        f0 = busy_falls;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = 8'($urandom);
            bit a = 1'($urandom);
            wait_empty();
            push_frame(d, m, a);
            write_byte(d, a);
        end
        wait_idle();
        compare_stream(req);
        check(busy_falls - f0 == 1, {req, " single busy span"}, busy_falls - f0, 1);
    endtask

    // watchdog
    initial begin
        #1000000;
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check(hold_empty == 1, "R1 empty", hold_empty, 1);
        check(tx_busy == 0, "R1 busy", tx_busy, 0);
        check(txd == 1, "R1 txd", txd, 1);
        check(tx_irq == 0, "R1 irq", tx_irq, 0);
        // R2 immediate request on enable
        irq_en = 1'b1; #1;
        check(tx_irq == 1, "R2 irq on enable", tx_irq, 1);
        // R3/R4 write on an idle shifter
        mode = 2'b00;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hA5;
        push_frame(8'hA5, 2'b00, 1'b0);
        @(negedge clk); wr_en = 1'b0; #1;
        check(hold_empty == 0, "R3 cleared after write", hold_empty, 0);
        check(tx_irq == 0, "R2 irq drops", tx_irq, 0);
        @(negedge clk); #1;
        check(hold_empty == 1, "R4 set on load", hold_empty, 1);
        check(tx_busy == 1, "R4 busy on load", tx_busy, 1);
        check(txd == 0, "R5 start bit", txd, 0);
        check(tx_irq == 1, "R2 irq back", tx_irq, 1);
        // R3 overwrite of a pending byte
        write_byte(8'h3C, 1'b0); #1;
        check(hold_empty == 0, "R3 pending", hold_empty, 0);
        write_byte(8'hC3, 1'b0); #1;
        check(hold_empty == 0, "R3 overwrite keeps flag", hold_empty, 0);
        push_frame(8'hC3, 2'b00, 1'b0);
        wait_idle();
        compare_stream("R3 overwrite stream");
        check(txd == 1, "R9 idle high", txd, 1);
        // R10 mode and address bit sampled at load
        mode = 2'b01;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h96; addr_bit = 1'b1;
        push_frame(8'h96, 2'b01, 1'b1);
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        mode = 2'b00; addr_bit = 1'b0;
        wait_idle();
        compare_stream("R10 sampled at load");
        // random bursts per mode
        for (int r = 0; r < 3; r++) begin
            random_burst(2'b00, "R5 R8 async");
            random_burst(2'b01, "R6 addr");
            random_burst(2'b10, "R7 sync");
            random_burst(2'b11, "R7 sync alt");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule